// File: doc/BRIEF.md
# ATM Receive Reassembly Channel Tracker

This block tracks reassembly progress for every receive channel of an ATM cell path. For each arriving cell it takes a channel index, the 3-bit payload type (PTI) and an end-of-packet flag. It keeps two 32-bit words per channel. The host writes a static configuration word. The block maintains a dynamic status word and reloads it from the configuration word whenever a packet opens. Cells marked as VC-level OAM are steered to channel 0. Channel 0 is reserved: it runs as a null-AAL channel one cell long, so each cell it takes closes at once.

Each accepted cell advances a length counter. The counter is preset to the two's complement of the buffer size and counts up towards zero. Cells that carry the congestion indication are counted in the same status word. When a packet closes, the block emits a completion record one cycle after the closing cell. The record holds the channel, the congestion count, a buffer-overflow flag and the number of cells. A cell on a channel that is switched off is dropped and flagged by a drop strobe.

Top module: `atm_rx_chan_tracker`

## Requirements
- R1: A cell whose PTI is 100 or 101 is handled on channel 0, whatever its channel index, and the channel it named is not touched. Any cell handled on channel 0 (a steered cell, or a cell indexed to channel 0 directly) gives a completion with channel 0, cells 1 and overflow 0. Host writes to address 0 have no effect.
- R2: Both words use the same layout: bit 31 owner/active, bit 30 channel on, bit 29 buffer size select, bit 28 null-AAL, bit 25 AAL3/4, bit 24 and bit 23 end-of-packet wait controls, bit 22 unused, bits 21..11 congestion count, bits 10..0 length counter. A cell arriving on an inactive channel opens a packet: the status word becomes the configuration word with bit 31 set and the congestion count cleared.
- R3: On a null-AAL channel (bit 28 set) the packet closes on the cell that brings the length counter to zero, with overflow 0, and the end-of-packet flag is ignored. A buffer of N cells (length preset 2048-N) therefore yields a completion with cells N.
- R4: On a channel with bit 28 clear (AAL5 or AAL3/4), a cell with end-of-packet set closes the packet with overflow 0 and reports the number of cells received in it.
- R5: On a channel with bit 28 clear, a cell without end-of-packet that brings the length counter to zero closes the packet with overflow 1. The next cell on that channel opens a new packet.
- R6: On a channel with bit 28 clear, an end-of-packet cell that brings the counter to zero exactly closes the packet with overflow 0.
- R7: The congestion count in the completion equals the number of cells in the packet whose PTI is 010 or 011. Other PTI values are not counted, and the count restarts from zero in each packet.
- R8: A cell that would open a packet on a channel whose channel-on bit (bit 30) is clear pulses the drop strobe one cycle later, gives no completion and changes no channel state.
- R9: A host configuration write changes nothing in an open packet. It is used from that channel's next packet start on.
- R10: After reset all channels are inactive and all configuration words are zero, and neither the completion strobe nor the drop strobe is asserted.
- R11: A completion appears as a one-cycle strobe exactly one cycle after the closing cell. Cells on any channels may arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellValid | input | 1 | A cell header is presented this cycle |
| cellChan | input | CH_W | Channel index of the cell |
| cellPti | input | 3 | Payload type field of the cell |
| cellEop | input | 1 | Cell is the last of its packet |
| cfgWrEn | input | 1 | Host configuration write strobe |
| cfgAddr | input | CH_W | Channel whose configuration word is written |
| cfgData | input | 32 | Configuration word to store |
| cmplValid | output | 1 | Completion record valid (one cycle) |
| cmplChan | output | CH_W | Channel of the closed packet |
| cmplCong | output | 11 | Congestion-marked cells in the packet |
| cmplOverflow | output | 1 | Packet was cut short by a full buffer |
| cmplCells | output | 11 | Cells received in the packet |
| dropPulse | output | 1 | A cell was dropped on a disabled channel |

## Verification
The hardest case to reach is an OAM cell that arrives in the middle of an open packet on the very channel it names. Only the later completion of that channel's packet can show that the steered cell left its counters alone. The stimulus opens an AAL5 packet, sends OAM cells indexed to that channel and to others, and then closes the packet. The expected cell and congestion counts come from a reference model kept in the bench. The other hard case is a configuration rewrite in the middle of a packet, including a switch-off. It is reached by writing between cells of an open packet. The bench then checks that the packet still closes by the old settings and that only the next packet start sees the new word.

// File: rtl/rxtrk_pkg.sv
package rxtrk_pkg;
  localparam int WORD_W = 32;
  localparam int CONG_W = 11;
  localparam int LEN_W  = 11;

  typedef struct packed {
    logic              own;
    logic              chanOn;
    logic              bigBuf;
    logic              nullAal;
    logic [1:0]        ctlSpare;
    logic              aal34;
    logic              eopWait;
    logic              eopWaitEn;
    logic              gapBit;
    logic [CONG_W-1:0] congCnt;
    logic [LEN_W-1:0]  lenCnt;
  } chan_word_t;

  typedef struct packed {
    logic accept;
    logic finish;
    logic overflow;
    logic efcn;
  } ctrl_strb_t;

  localparam chan_word_t OAM_WORD = '{
    own: 1'b0, chanOn: 1'b1, bigBuf: 1'b0, nullAal: 1'b1,
    ctlSpare: 2'b00, aal34: 1'b0, eopWait: 1'b0, eopWaitEn: 1'b0,
    gapBit: 1'b0, congCnt: '0, lenCnt: '1};
endpackage

// File: rtl/rxtrk_ctrl.sv
module rxtrk_ctrl
  import rxtrk_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cellValid,
  input  logic [CH_W-1:0] cellChan,
  input  logic [2:0]      cellPti,
  input  logic            cellEop,
  input  logic            effOn,
  input  logic            effNull,
  input  logic            lenHitsZero,
  output logic [CH_W-1:0] selChan,
  output ctrl_strb_t      strb,
  output logic            dropPulse
);
  logic isOam;
  logic dropNow;

  assign isOam = (cellPti[2:1] == 2'b10);
  assign selChan = isOam ? '0 : cellChan;

  always_comb begin
    strb = '0;
    strb.accept = cellValid && effOn;
    strb.efcn = (cellPti[2:1] == 2'b01);
    if (effNull) begin
      strb.finish = strb.accept && lenHitsZero;
    end else begin
      strb.finish = strb.accept && (cellEop || lenHitsZero);
      strb.overflow = strb.accept && lenHitsZero && !cellEop;
    end
  end

  assign dropNow = cellValid && !effOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dropPulse <= 1'b0;
    else       dropPulse <= dropNow;
  end
endmodule

// File: rtl/rxtrk_dpath.sv
module rxtrk_dpath
  import rxtrk_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_W-1:0]   selChan,
  input  ctrl_strb_t        strb,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  output logic              effOn,
  output logic              effNull,
  output logic              lenHitsZero,
  output logic              cmplValid,
  output logic [CH_W-1:0]   cmplChan,
  output logic [CONG_W-1:0] cmplCong,
  output logic              cmplOverflow,
  output logic [LEN_W-1:0]  cmplCells
);
  chan_word_t       cfgWord [NUM_CH];
  chan_word_t       statMem [NUM_CH];
  logic [LEN_W-1:0] cellCnt [NUM_CH];

  // Per-channel configuration registers; channel 0 is hardwired for OAM.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
    if (i == 0) begin : g_oam
      assign cfgWord[i] = OAM_WORD;
    end else begin : g_host
      chan_word_t cfgReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cfgReg <= '0;
        else if (cfgWrEn && (cfgAddr == CH_W'(i))) cfgReg <= chan_word_t'(cfgData);
      end
      assign cfgWord[i] = cfgReg;
    end
  end

  chan_word_t       curStat;
  chan_word_t       startWord;
  chan_word_t       effWord;
  chan_word_t       nextWord;
  logic [LEN_W-1:0] effCnt;
  logic [LEN_W-1:0] nextLen;
  logic [CONG_W-1:0] nextCong;

  assign curStat = statMem[selChan];

  always_comb begin
    startWord = cfgWord[selChan];
    startWord.own = 1'b1;
    startWord.gapBit = 1'b0;
    startWord.congCnt = '0;
  end

  assign effWord  = curStat.own ? curStat : startWord;
  assign effCnt   = curStat.own ? cellCnt[selChan] : '0;
  assign nextLen  = effWord.lenCnt + LEN_W'(1);
  assign nextCong = effWord.congCnt + CONG_W'(strb.efcn);

  assign effOn       = effWord.chanOn;
  assign effNull     = effWord.nullAal;
  assign lenHitsZero = (nextLen == '0);

  always_comb begin
    nextWord = effWord;
    nextWord.own = !strb.finish;
    nextWord.congCnt = nextCong;
    nextWord.lenCnt = nextLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        statMem[c] <= '0;
        cellCnt[c] <= '0;
      end
    end else if (strb.accept) begin
      statMem[selChan] <= nextWord;
      cellCnt[selChan] <= strb.finish ? '0 : effCnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmplValid    <= 1'b0;
      cmplChan     <= '0;
      cmplCong     <= '0;
      cmplOverflow <= 1'b0;
      cmplCells    <= '0;
    end else begin
      cmplValid <= strb.accept && strb.finish;
      if (strb.accept && strb.finish) begin
        cmplChan     <= selChan;
        cmplCong     <= nextCong;
        cmplOverflow <= strb.overflow;
        cmplCells    <= effCnt + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/atm_rx_chan_tracker.sv
module atm_rx_chan_tracker
  import rxtrk_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellValid,
  input  logic [CH_W-1:0]   cellChan,
  input  logic [2:0]        cellPti,
  input  logic              cellEop,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  output logic              cmplValid,
  output logic [CH_W-1:0]   cmplChan,
  output logic [CONG_W-1:0] cmplCong,
  output logic              cmplOverflow,
  output logic [LEN_W-1:0]  cmplCells,
  output logic              dropPulse
);
  logic [CH_W-1:0] selChan;
  ctrl_strb_t      strb;
  logic            effOn;
  logic            effNull;
  logic            lenHitsZero;

  rxtrk_ctrl #(.CH_W(CH_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cellValid(cellValid), .cellChan(cellChan), .cellPti(cellPti), .cellEop(cellEop),
    .effOn(effOn), .effNull(effNull), .lenHitsZero(lenHitsZero),
    .selChan(selChan), .strb(strb), .dropPulse(dropPulse)
  );

  rxtrk_dpath #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dpath_i (
    .clk(clk), .rstN(rstN),
    .selChan(selChan), .strb(strb),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .effOn(effOn), .effNull(effNull), .lenHitsZero(lenHitsZero),
    .cmplValid(cmplValid), .cmplChan(cmplChan), .cmplCong(cmplCong),
    .cmplOverflow(cmplOverflow), .cmplCells(cmplCells)
  );
endmodule

// File: rtl/rxtrk_checker.sv
module rxtrk_checker #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            cellValid,
  input logic [2:0]      cellPti,
  input logic            cellEop,
  input logic            cmplValid,
  input logic [CH_W-1:0] cmplChan,
  input logic            cmplOverflow,
  input logic [10:0]     cmplCells,
  input logic            dropPulse
);
  // R10: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R10: assert (!cmplValid && !dropPulse)
        else $error("outputs active during reset");
    end
  end

  assert_cmpl_after_cell_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> $past(cellValid));

  assert_drop_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> (!cmplValid && $past(cellValid)));

  assert_oam_steer_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && cellPti[2:1] == 2'b10) |=> (cmplValid && cmplChan == '0));

  assert_oam_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplChan == '0) |-> (cmplCells == 11'd1 && !cmplOverflow));

  assert_ovf_no_eop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplOverflow) |-> !$past(cellEop));
endmodule

bind atm_rx_chan_tracker rxtrk_checker #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellPti(cellPti),
  .cellEop(cellEop), .cmplValid(cmplValid), .cmplChan(cmplChan),
  .cmplOverflow(cmplOverflow), .cmplCells(cmplCells), .dropPulse(dropPulse)
);

// File: tb/atm_rx_chan_tracker_tb_top.sv
`timescale 1ns/1ps
module atm_rx_chan_tracker_tb_top;
  localparam int NCH = 16;
  localparam int CW = 4;
  localparam logic [31:0] ON  = 32'h4000_0000;
  localparam logic [31:0] NUL = 32'h1000_0000;
  localparam logic [31:0] A34 = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellValid = 1'b0;
  logic [CW-1:0] cellChan = '0;
  logic [2:0]  cellPti = '0;
  logic        cellEop = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [CW-1:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        cmplValid;
  logic [CW-1:0] cmplChan;
  logic [10:0] cmplCong;
  logic        cmplOverflow;
  logic [10:0] cmplCells;
  logic        dropPulse;

  always #2 clk = ~clk;

  atm_rx_chan_tracker #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellChan(cellChan),
    .cellPti(cellPti), .cellEop(cellEop), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cmplValid(cmplValid), .cmplChan(cmplChan),
    .cmplCong(cmplCong), .cmplOverflow(cmplOverflow), .cmplCells(cmplCells),
    .dropPulse(dropPulse)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    bit    isDrop;
    int    chan;
    int    cong;
    bit    ovf;
    int    cells;
    int    due;
    string tag;
  } item_t;
  item_t sbq[$];

  // reference state, derived from the requirements
  logic [31:0] mCfg [NCH];
  bit          mOwn [NCH];
  bit          mNull[NCH];
  logic [10:0] mLen [NCH];
  logic [10:0] mCong[NCH];
  logic [10:0] mCnt [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lenOf(int n);
    return 32'((2048 - n) & 11'h7FF);
  endfunction

  task automatic writeCfg(int ch, logic [31:0] d);
    @(negedge clk);
    cellValid = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = CW'(ch); cfgData = d;
    if (ch != 0) mCfg[ch] = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendCell(int ch, logic [2:0] pti, bit eop, string tag);
    item_t it;
    int e;
    bit efcn;
    bit fin;
    @(negedge clk);
    cellValid = 1'b1; cellChan = CW'(ch); cellPti = pti; cellEop = eop;
    e = (pti[2:1] == 2'b10) ? 0 : ch;
    efcn = (pti[2:1] == 2'b01);
    it.isDrop = 0; it.chan = e; it.ovf = 0; it.due = cyc + 1; it.tag = tag;
    if (e == 0) begin
      it.cong = int'(efcn); it.cells = 1;
      sbq.push_back(it);
    end else if (!mOwn[e] && !mCfg[e][30]) begin
      it.isDrop = 1; it.cong = 0; it.cells = 0;
      sbq.push_back(it);
    end else begin
      if (!mOwn[e]) begin
        mOwn[e] = 1; mNull[e] = mCfg[e][28]; mLen[e] = mCfg[e][10:0];
        mCong[e] = '0; mCnt[e] = '0;
      end
      mLen[e] = mLen[e] + 11'd1;
      mCong[e] = mCong[e] + 11'(efcn);
      mCnt[e] = mCnt[e] + 11'd1;
      if (mNull[e]) fin = (mLen[e] == 0);
      else begin
        fin = eop || (mLen[e] == 0);
        it.ovf = !eop && (mLen[e] == 0);
      end
      if (fin) begin
        it.cong = int'(mCong[e]); it.cells = int'(mCnt[e]);
        mOwn[e] = 0;
        sbq.push_back(it);
      end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cellValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        if (it.isDrop) begin
          check(dropPulse == 1'b1, it.tag, "dropPulse", int'(dropPulse), 1);
          check(cmplValid == 1'b0, it.tag, "cmplValid on drop", int'(cmplValid), 0);
        end else begin
          check(cmplValid == 1'b1, it.tag, "cmplValid", int'(cmplValid), 1);
          check(dropPulse == 1'b0, it.tag, "dropPulse", int'(dropPulse), 0);
          check(int'(cmplChan) == it.chan, it.tag, "cmplChan", int'(cmplChan), it.chan);
          check(int'(cmplCong) == it.cong, it.tag, "cmplCong", int'(cmplCong), it.cong);
          check(cmplOverflow == it.ovf, it.tag, "cmplOverflow", int'(cmplOverflow), int'(it.ovf));
          check(int'(cmplCells) == it.cells, it.tag, "cmplCells", int'(cmplCells), it.cells);
        end
      end else if (cmplValid || dropPulse) begin
        check(1'b0, "R11", "unexpected output strobe", int'({cmplValid, dropPulse}), 0);
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mCfg[c] = '0; mOwn[c] = 0; mNull[c] = 0; mLen[c] = '0; mCong[c] = '0; mCnt[c] = '0;
    end
    repeat (3) @(negedge clk);
    check(cmplValid == 1'b0, "R10", "cmplValid in reset", int'(cmplValid), 0);
    check(dropPulse == 1'b0, "R10", "dropPulse in reset", int'(dropPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmplValid == 1'b0, "R10", "cmplValid after reset", int'(cmplValid), 0);

    // R10: config cleared by reset, so the cell is dropped
    sendCell(3, 3'b000, 0, "R10");
    idle(2);

    // R3 / R2: null-AAL, three cells, EOP ignored
    writeCfg(1, ON | NUL | lenOf(3));
    sendCell(1, 3'b000, 1, "R3");
    sendCell(1, 3'b000, 0, "R3");
    sendCell(1, 3'b011, 0, "R2");
    idle(2);

    // R4 / R7: AAL5 closed by EOP
    writeCfg(2, ON | lenOf(4));
    sendCell(2, 3'b010, 0, "R4");
    sendCell(2, 3'b000, 0, "R4");
    sendCell(2, 3'b011, 1, "R7");
    idle(1);

    // R5: buffer fills without EOP; R7 other PTI not counted
    sendCell(2, 3'b001, 0, "R5");
    sendCell(2, 3'b110, 0, "R5");
    sendCell(2, 3'b111, 0, "R5");
    sendCell(2, 3'b000, 0, "R5");
    sendCell(2, 3'b010, 0, "R7");
    sendCell(2, 3'b000, 1, "R7");
    idle(1);

    // R6: EOP exactly on the filling cell
    sendCell(2, 3'b000, 0, "R6");
    sendCell(2, 3'b000, 0, "R6");
    sendCell(2, 3'b011, 0, "R6");
    sendCell(2, 3'b000, 1, "R6");
    idle(1);

    // R1: OAM steering in the middle of an open packet
    sendCell(2, 3'b010, 0, "R1");
    sendCell(2, 3'b100, 0, "R1");
    sendCell(7, 3'b101, 1, "R1");
    sendCell(0, 3'b011, 0, "R1");
    sendCell(2, 3'b000, 1, "R1");
    idle(1);

    // R8: disabled channels drop without disturbing others
    sendCell(4, 3'b010, 0, "R8");
    writeCfg(4, ON | lenOf(2));
    sendCell(4, 3'b011, 0, "R8");
    sendCell(6, 3'b000, 0, "R8");
    sendCell(4, 3'b000, 1, "R8");
    idle(1);

    // R9: mid-packet rewrite (off, shorter buffer) waits for next start
    writeCfg(5, ON | lenOf(8));
    sendCell(5, 3'b000, 0, "R9");
    sendCell(5, 3'b010, 0, "R9");
    writeCfg(5, lenOf(2));
    sendCell(5, 3'b000, 0, "R9");
    sendCell(5, 3'b000, 1, "R9");
    sendCell(5, 3'b000, 0, "R9");
    idle(1);

    // R1: host write to channel 0 has no effect
    writeCfg(0, 32'h0);
    sendCell(9, 3'b100, 0, "R1");
    idle(1);

    // R11: back-to-back interleaved channels
    sendCell(1, 3'b010, 0, "R11");
    sendCell(2, 3'b011, 0, "R11");
    sendCell(1, 3'b000, 0, "R11");
    sendCell(2, 3'b000, 1, "R11");
    sendCell(1, 3'b011, 0, "R11");
    idle(1);

    // R5: AAL3/4 channel overflow, then a fresh packet
    writeCfg(7, ON | A34 | lenOf(2));
    sendCell(7, 3'b000, 0, "R5");
    sendCell(7, 3'b010, 0, "R5");
    sendCell(7, 3'b000, 0, "R5");
    sendCell(7, 3'b000, 1, "R5");
    idle(4);

    check(sbq.size() == 0, "R11", "expected records left", sbq.size(), 0);
    finishRun();
  end
endmodule